// File: doc/BRIEF.md
# In-Place CBC Decryption Sequencer

This block turns an external single-block AES-256 decrypt engine into a cipher-block-chaining decryptor for a fixed 1200-byte buffer. The buffer holds 75 sixteen-byte blocks. The block works in place. For each block it reads the four ciphertext words from the buffer and keeps a copy of them. It hands the block to the engine and waits for the answer. It then XORs that answer word by word with the current chaining value and writes the four plaintext words back over the ciphertext. The copied ciphertext becomes the chaining value for the next block. The first chaining value is a 128-bit IV given as four 32-bit words at start.

A single start pulse from idle captures the IV and the 256-bit derived key, and the block then runs with no further help. The buffer port is word-addressed with a one-cycle read latency. The engine sees one request at a time through a request/acknowledge handshake. After the last block is written back, the block pulses done and, in that same cycle, asks the engine to reset itself.

Top module: `cbc_decrypt_chain`

## Requirements
- R1: After a synchronous active-low reset, busy, done, the engine request, the engine reset request and both buffer enables are all low.
- R2: A start pulse while idle captures the IV and key, and busy is high from the next cycle.
- R3: Each plaintext word w of a block equals word w of the engine output XOR word w of the chaining value. Word w of any 128-bit value sits at bits 32w+31..32w. Word w of the IV input is IV word w.
- R4: The chaining value for block 0 is the IV. For block b>0 it is the ciphertext of block b-1 as read before that block was overwritten.
- R5: Block b lives at word addresses 4b..4b+3. Only addresses 0 to 299 are ever read or written, and each one is rewritten with its plaintext.
- R6: Only one block is outstanding. The engine request stays high with unchanged data until acknowledge, and there is no buffer access while it is pending.
- R7: The key given to the engine equals the key captured at start and stays constant for the whole run.
- R8: One cycle after the last write of block 74, done is high for exactly one cycle together with the engine reset request. Busy is low after that cycle.
- R9: A start pulse while busy is ignored: the result still uses the IV and key captured at the first start, and only one done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| iv_i | input | 128 | Initial chaining value, word w at bits 32w+31..32w |
| key_i | input | 256 | Derived decryption key |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| buf_addr_o | output | 9 | Buffer word address |
| buf_rd_en_o | output | 1 | Buffer read enable, data returns next cycle |
| buf_rdata_i | input | 32 | Buffer read data |
| buf_wr_en_o | output | 1 | Buffer write enable |
| buf_wdata_o | output | 32 | Buffer write data |
| core_req_o | output | 1 | Engine block request |
| core_din_o | output | 128 | Ciphertext block to the engine |
| core_key_o | output | 256 | Key to the engine |
| core_ack_i | input | 1 | Engine result valid |
| core_dout_i | input | 128 | Engine decrypt output |
| core_rst_req_o | output | 1 | Engine reset request, pulsed at completion |

## Verification
The bench uses three buffer contents. An address-hashed ciphertext gives every block its own value, so a swapped word, a wrong address or a skipped block shows up. A ciphertext with every block identical separates true chaining from plain per-block decryption: only block 0 differs from the rest, and an implementation that does not chain or chains the wrong value gives the wrong pattern. An all-zero ciphertext with a nonzero IV isolates the IV path in block 0. The engine model answers after a varying number of cycles to exercise the handshake, and a second start with a different IV and key is injected during one run.

// File: rtl/cbc_pkg.sv
// Shared types for the CBC decryption sequencer.
package cbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_REQ  = 3'd2,
        ST_WB   = 3'd3,
        ST_FIN  = 3'd4
    } cbc_state_e;
endpackage

// File: rtl/cbc_seq.sv
// Control sequencer: walks the blocks, issues buffer reads, the engine
// request and the write-back. Assumes the buffer returns read data one
// cycle after the read enable and WPB >= 2.
module cbc_seq
    import cbc_pkg::*;
#(
    parameter int NUM_BLOCKS = 75,
    parameter int WPB        = 4,
    localparam int AW        = $clog2(NUM_BLOCKS * WPB),
    localparam int IW        = $clog2(WPB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          core_ack_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          core_rst_req_o,
    output logic          core_req_o,
    output logic          load_o,
    output logic          fire_o,
    output logic          cap_en_o,
    output logic [IW-1:0] cap_idx_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [AW-1:0] buf_addr_o,
    output logic          buf_rd_en_o,
    output logic          buf_wr_en_o
);
    localparam int RW = $clog2(WPB + 1);
    localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

    cbc_state_e    state;
    logic [BW-1:0] blk;
    logic [RW-1:0] rcnt;
    logic [IW-1:0] wcnt;
    logic          pend;
    logic [IW-1:0] pidx;
    logic [AW-1:0] base;

    // Word address of word 0 of the current block.
    assign base = AW'(blk) * AW'(WPB);

    // Output decode from the current state and counters.
    always_comb begin
        busy_o         = (state != ST_IDLE);
        done_o         = (state == ST_FIN);
        core_rst_req_o = (state == ST_FIN);
        core_req_o     = (state == ST_REQ);
        load_o         = (state == ST_IDLE) && start_i;
        fire_o         = (state == ST_REQ) && core_ack_i;
        cap_en_o       = pend;
        cap_idx_o      = pidx;
        wr_idx_o       = wcnt;
        buf_rd_en_o    = (state == ST_LOAD) && (rcnt < RW'(WPB));
        buf_wr_en_o    = (state == ST_WB);
        if (state == ST_WB) buf_addr_o = base + AW'(wcnt);
        else                buf_addr_o = base + AW'(rcnt);
    end

    // State, block and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            blk   <= '0;
            rcnt  <= '0;
            wcnt  <= '0;
            pend  <= 1'b0;
            pidx  <= '0;
        end else begin
            pend <= buf_rd_en_o;
            pidx <= rcnt[IW-1:0];
            case (state)
                ST_IDLE: if (start_i) begin
                    state <= ST_LOAD;
                    blk   <= '0;
                    rcnt  <= '0;
                end
                ST_LOAD: begin
                    if (buf_rd_en_o) rcnt <= rcnt + 1'b1;
                    if (pend && pidx == IW'(WPB - 1)) state <= ST_REQ;
                end
                ST_REQ: if (core_ack_i) begin
                    state <= ST_WB;
                    wcnt  <= '0;
                end
                ST_WB: begin
                    if (wcnt == IW'(WPB - 1)) begin
                        if (blk == BW'(NUM_BLOCKS - 1)) begin
                            state <= ST_FIN;
                        end else begin
                            blk   <= blk + 1'b1;
                            rcnt  <= '0;
                            state <= ST_LOAD;
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: start from idle makes the block busy next cycle.
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);
    // R6: a pending request is held until acknowledged.
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_o && !core_ack_i) |=> core_req_o);
    // R6: no buffer traffic while the engine holds the block.
    a_r6_no_bus_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        core_req_o |-> !(buf_rd_en_o || buf_wr_en_o));
    // R5: addresses stay inside the buffer.
    a_r5_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd_en_o || buf_wr_en_o) |-> (int'(buf_addr_o) < NUM_BLOCKS * WPB));
    // R8: done lasts one cycle and busy then drops.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

// File: rtl/cbc_chain_dp.sv
// Datapath: ciphertext capture, chaining register, plaintext XOR and
// key hold. Assumes controls come from cbc_seq, one strobe per event.
module cbc_chain_dp #(
    parameter int WORD_W = 32,
    parameter int WPB    = 4,
    parameter int KEY_W  = 256,
    localparam int BLK_W = WORD_W * WPB,
    localparam int IW    = $clog2(WPB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              fire_i,
    input  logic              cap_en_i,
    input  logic [IW-1:0]     cap_idx_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic [BLK_W-1:0]  iv_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [WORD_W-1:0] rdata_i,
    input  logic [BLK_W-1:0]  core_dout_i,
    output logic [BLK_W-1:0]  core_din_o,
    output logic [KEY_W-1:0]  core_key_o,
    output logic [WORD_W-1:0] wdata_o
);
    logic [WPB-1:0][WORD_W-1:0] ct;
    logic [WPB-1:0][WORD_W-1:0] chain;
    logic [WPB-1:0][WORD_W-1:0] pt;
    logic [KEY_W-1:0]           key_q;

    // Per-word ciphertext capture, chaining update and plaintext XOR.
    for (genvar w = 0; w < WPB; w++) begin : g_word
        // Capture ciphertext word w as it returns from the buffer.
        always_ff @(posedge clk) begin
            if (!rst_n)                              ct[w] <= '0;
            else if (cap_en_i && cap_idx_i == IW'(w)) ct[w] <= rdata_i;
        end
        // Chaining word w: IV at start, saved ciphertext after each block.
        always_ff @(posedge clk) begin
            if (!rst_n)      chain[w] <= '0;
            else if (load_i) chain[w] <= iv_i[w*WORD_W +: WORD_W];
            else if (fire_i) chain[w] <= ct[w];
        end
        // Plaintext word w from the engine result.
        always_ff @(posedge clk) begin
            if (!rst_n)      pt[w] <= '0;
            else if (fire_i) pt[w] <= core_dout_i[w*WORD_W +: WORD_W] ^ chain[w];
        end
    end

    // Key captured once per run.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (load_i) key_q <= key_i;
    end

    assign core_din_o = ct;
    assign core_key_o = key_q;
    assign wdata_o    = pt[wr_idx_i];

    // R9: the chaining value moves only on start from idle or a result.
    a_r9_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !fire_i) |=> $stable(chain));
    // R7: the key changes only when a run is started.
    a_r7_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(core_key_o));
endmodule

// File: rtl/cbc_decrypt_chain.sv
// Top: in-place CBC decryption of NUM_BLOCKS blocks around an external
// block-decrypt engine. Assumes a one-cycle-latency word buffer and an
// engine that raises ack for one cycle with its result.
module cbc_decrypt_chain #(
    parameter int NUM_BLOCKS = 75,
    parameter int WORD_W     = 32,
    parameter int WPB        = 4,
    parameter int KEY_W      = 256,
    localparam int BLK_W     = WORD_W * WPB,
    localparam int AW        = $clog2(NUM_BLOCKS * WPB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BLK_W-1:0]  iv_i,
    input  logic [KEY_W-1:0]  key_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [AW-1:0]     buf_addr_o,
    output logic              buf_rd_en_o,
    input  logic [WORD_W-1:0] buf_rdata_i,
    output logic              buf_wr_en_o,
    output logic [WORD_W-1:0] buf_wdata_o,
    output logic              core_req_o,
    output logic [BLK_W-1:0]  core_din_o,
    output logic [KEY_W-1:0]  core_key_o,
    input  logic              core_ack_i,
    input  logic [BLK_W-1:0]  core_dout_i,
    output logic              core_rst_req_o
);
    localparam int IW = $clog2(WPB);

    logic          load;
    logic          fire;
    logic          cap_en;
    logic [IW-1:0] cap_idx;
    logic [IW-1:0] wr_idx;

    cbc_seq #(.NUM_BLOCKS(NUM_BLOCKS), .WPB(WPB)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .core_ack_i     (core_ack_i),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .core_rst_req_o (core_rst_req_o),
        .core_req_o     (core_req_o),
        .load_o         (load),
        .fire_o         (fire),
        .cap_en_o       (cap_en),
        .cap_idx_o      (cap_idx),
        .wr_idx_o       (wr_idx),
        .buf_addr_o     (buf_addr_o),
        .buf_rd_en_o    (buf_rd_en_o),
        .buf_wr_en_o    (buf_wr_en_o)
    );

    cbc_chain_dp #(.WORD_W(WORD_W), .WPB(WPB), .KEY_W(KEY_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .fire_i      (fire),
        .cap_en_i    (cap_en),
        .cap_idx_i   (cap_idx),
        .wr_idx_i    (wr_idx),
        .iv_i        (iv_i),
        .key_i       (key_i),
        .rdata_i     (buf_rdata_i),
        .core_dout_i (core_dout_i),
        .core_din_o  (core_din_o),
        .core_key_o  (core_key_o),
        .wdata_o     (buf_wdata_o)
    );

    // R6: the block sent to the engine does not change while pending.
    a_r6_din_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_o && !core_ack_i) |=> $stable(core_din_o));
    // R7: the engine key is constant during a run.
    a_r7_key_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(core_key_o));
    // R1/R8: the engine reset request appears only with completion.
    a_r8_rst_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req_o |-> (done_o && busy_o));
endmodule

// File: tb/tb_cbc_decrypt_chain.sv
module tb_cbc_decrypt_chain;
    localparam int NB    = 75;
    localparam int NW    = NB * 4;
    localparam int MEMSZ = 320;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] iv = '0;
    logic [255:0] key = '0;
    logic         busy, done, rd_en, wr_en, core_req, core_ack, core_rst;
    logic [8:0]   addr;
    logic [31:0]  rdata, wdata;
    logic [127:0] core_din, core_dout;
    logic [255:0] core_key;

    logic [31:0]  mem [0:MEMSZ-1];
    logic [31:0]  expv [0:NW-1];
    int checks = 0;
    int failures = 0;
    int done_cnt = 0;
    int key_err = 0;
    int range_err = 0;
    int req_cnt = 0;
    int wait_cnt = 0;
    logic [255:0] run_key;

    always #10 clk = ~clk;

    cbc_decrypt_chain dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .iv_i(iv), .key_i(key),
        .busy_o(busy), .done_o(done), .buf_addr_o(addr), .buf_rd_en_o(rd_en),
        .buf_rdata_i(rdata), .buf_wr_en_o(wr_en), .buf_wdata_o(wdata),
        .core_req_o(core_req), .core_din_o(core_din), .core_key_o(core_key),
        .core_ack_i(core_ack), .core_dout_i(core_dout), .core_rst_req_o(core_rst)
    );

    function automatic logic [127:0] engine(input logic [127:0] x, input logic [255:0] k);
        return {x[119:0], x[127:120]} ^ k[127:0] ^ k[255:128];
    endfunction

    // Buffer model with one-cycle read latency.
    always @(posedge clk) begin
        if (rd_en) rdata <= mem[addr];
        if (wr_en) mem[addr] <= wdata;
    end

    // Engine model with latency 1..3 cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            core_ack <= 1'b0; wait_cnt <= 0;
        end else if (core_req && !core_ack) begin
            if (wait_cnt == req_cnt % 3) begin
                core_ack  <= 1'b1;
                core_dout <= engine(core_din, core_key);
                wait_cnt  <= 0;
                req_cnt   <= req_cnt + 1;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            core_ack <= 1'b0;
        end
    end

    // Event monitors.
    always @(posedge clk) begin
        if (rst_n) begin
            if (done) done_cnt <= done_cnt + 1;
            if (core_req && core_key !== run_key) key_err <= key_err + 1;
            if ((rd_en || wr_en) && addr >= 9'(NW)) range_err <= range_err + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input int pat, input logic [127:0] civ, input logic [255:0] ckey, input bit inject);
        logic [127:0] chain, ct, pt;
        int d0, k0, r0;
        for (int i = 0; i < MEMSZ; i++) begin
            case (pat)
                0:       mem[i] = i * 32'h9E3779B9 + 32'd1;
                1:       mem[i] = 32'hFFFF_FFFF;
                default: mem[i] = (i < NW) ? 32'h0 : 32'hA5A5_0000 + i;
            endcase
            if (pat == 2 && i >= NW) mem[i] = 32'hA5A5_0000 + i;
        end
        chain = civ;
        for (int b = 0; b < NB; b++) begin
            ct = {mem[4*b+3], mem[4*b+2], mem[4*b+1], mem[4*b]};
            pt = engine(ct, ckey) ^ chain;
            for (int w = 0; w < 4; w++) expv[4*b+w] = pt[32*w +: 32];
            chain = ct;
        end
        d0 = done_cnt; k0 = key_err; r0 = range_err;
        run_key = ckey;
        @(negedge clk);
        iv = civ; key = ckey; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        iv = ~civ; key = ~ckey;
        check(busy === 1'b1, "R2 busy after start", {127'd0, busy}, 128'd1);
        if (inject) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        check(core_rst === 1'b1, "R8 engine reset with done", {127'd0, core_rst}, 128'd1);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R8 done one cycle, idle after",
              {126'd0, done, busy}, 128'd0);
        check(done_cnt - d0 == 1, inject ? "R9 single done despite restart" : "R8 single done",
              128'(done_cnt - d0), 128'd1);
        // R3 R4 R5: every block holds its chained plaintext.
        for (int b = 0; b < NB; b++) begin
            logic [127:0] got, want;
            got  = {mem[4*b+3], mem[4*b+2], mem[4*b+1], mem[4*b]};
            want = {expv[4*b+3], expv[4*b+2], expv[4*b+1], expv[4*b]};
            check(got === want, inject ? "R9 R3 R4 plaintext block" : "R3 R4 plaintext block", got, want);
        end
        // R5: words past the buffer untouched and never addressed.
        for (int i = NW; i < MEMSZ; i++) begin
            logic [31:0] tail;
            case (pat)
                0:       tail = i * 32'h9E3779B9 + 32'd1;
                1:       tail = 32'hFFFF_FFFF;
                default: tail = 32'hA5A5_0000 + i;
            endcase
            if (mem[i] !== tail) begin
                check(1'b0, "R5 word outside buffer changed", 128'(mem[i]), 128'(tail));
            end
        end
        check(range_err == r0, "R5 address range", 128'(range_err - r0), 128'd0);
        check(key_err == k0, "R7 engine key", 128'(key_err - k0), 128'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && core_req === 1'b0 && core_rst === 1'b0 &&
              rd_en === 1'b0 && wr_en === 1'b0, "R1 reset state",
              {122'd0, busy, done, core_req, core_rst, rd_en, wr_en}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1 idle after reset", {126'd0, busy, done}, 128'd0);
        run_case(0, 128'h0F0E0D0C_0B0A0908_07060504_03020100,
                 256'h1111_2222_3333_4444_5555_6666_7777_8888_9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0123, 1'b0);
        run_case(1, 128'd0, 256'hDEADBEEF_00000000_CAFEF00D_12345678_0BADC0DE_FEEDFACE_01020304_A5A55A5A, 1'b1);
        run_case(2, 128'h80000000_00000001_55555555_AAAAAAAA, 256'd0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule